// File: doc/BRIEF.md
# Dead-Block Correlating Prefetch Predictor

This block watches the access stream of a first-level data cache and guesses when a resident block has been touched for the last time. For each cache frame it keeps a running signature. The signature starts at the miss that brings a block in, from the block address plus the PC of that miss. Each later hit to the frame adds the PC of the access. All sums wrap at the signature width.

A direct-mapped correlation table maps a final signature to the block that followed it in the same frame. Each entry carries a 2-bit saturating confidence counter. When the signature produced by an access matches a confident entry, the block declares the frame dead. One cycle later it asks the cache to evict the current block early and to prefetch the predicted block into that frame.

When the cache actually replaces a frame, it reports the frame and the incoming address on the training port. The table then learns from the evicted block's final signature.

Each frame moves through three named states:

- EMPTY: no block has been filled since reset. A hit here is ignored and leaves the frame EMPTY.
- LIVE: a fill miss moves any frame to LIVE and restarts its signature. A hit keeps the frame LIVE.
- DEAD: a confident match in LIVE moves the frame to DEAD. A hit keeps it DEAD and still adds to the signature. A miss takes it back to LIVE.

Each training report takes exactly one of five table actions:

- NONE: no report this cycle, or the frame is EMPTY.
- ALLOC: the tag is absent.
- REINFORCE: the tag matches and the stored next address equals the incoming one.
- WEAKEN: the tag matches, the next address differs and the counter is nonzero.
- REPLACE: the tag matches, the next address differs and the counter is zero.

Top module: `dbp_predictor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pf_valid` is 0. The history and table start empty, so no prediction occurs until training has happened.
- R2: On a miss, a frame's signature becomes (low SIG_W bits of address + low SIG_W bits of PC) mod 2^SIG_W. A hit to a non-EMPTY frame adds the low SIG_W PC bits, mod 2^SIG_W.
- R3: The table is direct-mapped. The low IDX_W signature bits select the entry and the upper SIG_W-IDX_W bits form its tag. A training report whose tag is absent allocates the entry with the incoming address and a counter of 1.
- R4: A training report with a matching tag works as follows. If the stored next address equals the incoming one, the counter increments, saturating at 3. Otherwise, a nonzero counter decrements. At 0, the next address is replaced by the incoming one and the counter is set to 1.
- R5: A prediction needs a valid entry whose tag matches the new signature and whose counter is 2 or 3.
- R6: A prediction appears one cycle after the access that caused it, as a one-cycle pulse on `pf_valid`. `pf_frame` gives the accessed frame, `pf_evict_addr` the access address and `pf_fetch_addr` the entry's next address.
- R7: Once a frame has been declared dead, it yields no further prediction until a miss to that frame restarts its trace.
- R8: A hit to an EMPTY frame is ignored: it changes no signature and yields no prediction.
- R9: A training report naming an EMPTY frame leaves the table unchanged.
- R10: When an access and a training report arrive in the same cycle, both see the table and signatures as they were before that cycle. Training therefore uses the signature held before the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is observed this cycle |
| acc_frame | input | FRAME_W | Cache frame of the access |
| acc_addr | input | ADDR_W | Block address of the access |
| acc_pc | input | PC_W | PC of the accessing instruction |
| acc_hit | input | 1 | 1 = hit, 0 = miss that fills the frame |
| trn_valid | input | 1 | A frame is being replaced this cycle |
| trn_frame | input | FRAME_W | Frame being replaced |
| trn_addr | input | ADDR_W | Block address coming into that frame |
| pf_valid | output | 1 | Dead-block prediction pulse |
| pf_frame | output | FRAME_W | Frame predicted dead |
| pf_evict_addr | output | ADDR_W | Block to evict early |
| pf_fetch_addr | output | ADDR_W | Block to prefetch into the frame |

## Verification
The assertions check several properties on every cycle:

- A prediction always echoes the frame and address of the access one cycle earlier.
- No frame is declared dead twice within one lifetime.
- Predictions never name a frame that has never been filled.
- No prediction occurs before at least two training reports.

Only the bench's scenarios can show the following, through a behavioural model compared on every clock:

- The exact signature arithmetic, with wraparound.
- The counter climbing to confidence and falling back with address replacement.
- Tag aliasing between entries.
- That hits and trainings on empty frames leave later predictions unchanged.
- That same-cycle access and training both use the state from before that cycle.

// File: rtl/dbp_pkg.sv
`timescale 1ns/1ps
package dbp_pkg;

    // Lifecycle of one cache frame as seen by the predictor
    typedef enum logic [1:0] {
        FR_EMPTY = 2'd0,
        FR_LIVE  = 2'd1,
        FR_DEAD  = 2'd2
    } frame_st_e;

    // What one training report does to its table entry
    typedef enum logic [2:0] {
        TR_NONE      = 3'd0,
        TR_ALLOC     = 3'd1,
        TR_REINFORCE = 3'd2,
        TR_WEAKEN    = 3'd3,
        TR_REPLACE   = 3'd4
    } train_act_e;

    localparam logic [1:0] CNT_MAX  = 2'd3;
    localparam logic [1:0] CNT_CONF = 2'd2;
    localparam logic [1:0] CNT_INIT = 2'd1;

endpackage

// File: rtl/dbp_hist.sv
`timescale 1ns/1ps
module dbp_hist
    import dbp_pkg::*;
#(
    parameter int FRAME_W = 4,
    parameter int ADDR_W  = 16,
    parameter int PC_W    = 16,
    parameter int SIG_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [FRAME_W-1:0] acc_frame,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [PC_W-1:0]    acc_pc,
    input  logic               acc_hit,
    input  logic               kill,
    input  logic [FRAME_W-1:0] trn_frame,
    output logic [SIG_W-1:0]   new_sig,
    output logic               upd,
    output logic               live_after,
    output logic [SIG_W-1:0]   trn_sig,
    output logic               trn_occ
);
    localparam int NFR = 1 << FRAME_W;

    logic [SIG_W-1:0] sig_q [NFR];
    frame_st_e        st_q  [NFR];

    frame_st_e cur_st;
    frame_st_e st_step;
    frame_st_e st_fin;

    always_comb begin
        cur_st  = st_q[acc_frame];
        st_step = cur_st;
        upd     = 1'b0;
        if (acc_valid) begin
            if (!acc_hit) begin
                st_step = FR_LIVE;
                upd     = 1'b1;
            end else begin
                unique case (cur_st)
                    FR_EMPTY: begin st_step = FR_EMPTY; upd = 1'b0; end
                    FR_LIVE:  begin st_step = FR_LIVE;  upd = 1'b1; end
                    FR_DEAD:  begin st_step = FR_DEAD;  upd = 1'b1; end
                    default:  begin st_step = FR_EMPTY; upd = 1'b0; end
                endcase
            end
        end
        live_after = upd && (st_step == FR_LIVE);
        st_fin     = kill ? FR_DEAD : st_step;
    end

    always_comb begin
        if (acc_hit) new_sig = sig_q[acc_frame] + acc_pc[SIG_W-1:0];
        else         new_sig = acc_addr[SIG_W-1:0] + acc_pc[SIG_W-1:0];
    end

    assign trn_sig = sig_q[trn_frame];
    assign trn_occ = (st_q[trn_frame] != FR_EMPTY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NFR; i++) begin
                sig_q[i] <= '0;
                st_q[i]  <= FR_EMPTY;
            end
        end else if (upd) begin
            sig_q[acc_frame] <= new_sig;
            st_q[acc_frame]  <= st_fin;
        end
    end

endmodule

// File: rtl/dbp_ctab.sv
`timescale 1ns/1ps
module dbp_ctab
    import dbp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIG_W  = 12,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIG_W-1:0]  lk_sig,
    output logic              lk_conf,
    output logic [ADDR_W-1:0] lk_next,
    input  logic              tr_valid,
    input  logic [SIG_W-1:0]  tr_sig,
    input  logic [ADDR_W-1:0] tr_addr
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = SIG_W - IDX_W;

    logic              v_q   [DEPTH];
    logic [TAG_W-1:0]  tag_q [DEPTH];
    logic [ADDR_W-1:0] nxt_q [DEPTH];
    logic [1:0]        cnt_q [DEPTH];

    logic [IDX_W-1:0] li, ti;
    logic [TAG_W-1:0] lt, tt;
    logic             t_hit;
    train_act_e       act;

    assign li = lk_sig[IDX_W-1:0];
    assign lt = lk_sig[SIG_W-1:IDX_W];
    assign ti = tr_sig[IDX_W-1:0];
    assign tt = tr_sig[SIG_W-1:IDX_W];

    assign lk_conf = v_q[li] && (tag_q[li] == lt) && (cnt_q[li] >= CNT_CONF);
    assign lk_next = nxt_q[li];
    assign t_hit   = v_q[ti] && (tag_q[ti] == tt);

    always_comb begin
        if (!tr_valid)                act = TR_NONE;
        else if (!t_hit)              act = TR_ALLOC;
        else if (nxt_q[ti] == tr_addr) act = TR_REINFORCE;
        else if (cnt_q[ti] != 2'd0)   act = TR_WEAKEN;
        else                          act = TR_REPLACE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                v_q[i]   <= 1'b0;
                tag_q[i] <= '0;
                nxt_q[i] <= '0;
                cnt_q[i] <= '0;
            end
        end else begin
            unique case (act)
                TR_NONE: ;
                TR_ALLOC: begin
                    v_q[ti]   <= 1'b1;
                    tag_q[ti] <= tt;
                    nxt_q[ti] <= tr_addr;
                    cnt_q[ti] <= CNT_INIT;
                end
                TR_REINFORCE: begin
                    if (cnt_q[ti] != CNT_MAX) cnt_q[ti] <= cnt_q[ti] + 2'd1;
                end
                TR_WEAKEN: cnt_q[ti] <= cnt_q[ti] - 2'd1;
                TR_REPLACE: begin
                    nxt_q[ti] <= tr_addr;
                    cnt_q[ti] <= CNT_INIT;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dbp_predictor.sv
`timescale 1ns/1ps
module dbp_predictor
    import dbp_pkg::*;
#(
    parameter int FRAME_W = 4,
    parameter int ADDR_W  = 16,
    parameter int PC_W    = 16,
    parameter int SIG_W   = 12,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [FRAME_W-1:0] acc_frame,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [PC_W-1:0]    acc_pc,
    input  logic               acc_hit,
    input  logic               trn_valid,
    input  logic [FRAME_W-1:0] trn_frame,
    input  logic [ADDR_W-1:0]  trn_addr,
    output logic               pf_valid,
    output logic [FRAME_W-1:0] pf_frame,
    output logic [ADDR_W-1:0]  pf_evict_addr,
    output logic [ADDR_W-1:0]  pf_fetch_addr
);
    logic [SIG_W-1:0]  new_sig, trn_sig;
    logic              upd, live_after, trn_occ;
    logic              lk_conf, fire;
    logic [ADDR_W-1:0] lk_next;

    assign fire = live_after && lk_conf;

    dbp_hist #(
        .FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .PC_W(PC_W), .SIG_W(SIG_W)
    ) u_hist (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_addr(acc_addr),
        .acc_pc(acc_pc), .acc_hit(acc_hit), .kill(fire),
        .trn_frame(trn_frame),
        .new_sig(new_sig), .upd(upd), .live_after(live_after),
        .trn_sig(trn_sig), .trn_occ(trn_occ)
    );

    dbp_ctab #(
        .ADDR_W(ADDR_W), .SIG_W(SIG_W), .IDX_W(IDX_W)
    ) u_ctab (
        .clk(clk), .rst_n(rst_n),
        .lk_sig(new_sig), .lk_conf(lk_conf), .lk_next(lk_next),
        .tr_valid(trn_valid && trn_occ), .tr_sig(trn_sig), .tr_addr(trn_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid      <= 1'b0;
            pf_frame      <= '0;
            pf_evict_addr <= '0;
            pf_fetch_addr <= '0;
        end else begin
            pf_valid <= fire;
            if (fire) begin
                pf_frame      <= acc_frame;
                pf_evict_addr <= acc_addr;
                pf_fetch_addr <= lk_next;
            end
        end
    end

endmodule

// File: rtl/dbp_predictor_chk.sv
`timescale 1ns/1ps
module dbp_predictor_chk #(
    parameter int FRAME_W = 4,
    parameter int ADDR_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic [FRAME_W-1:0] acc_frame,
    input logic [ADDR_W-1:0]  acc_addr,
    input logic               acc_hit,
    input logic               trn_valid,
    input logic               pf_valid,
    input logic [FRAME_W-1:0] pf_frame,
    input logic [ADDR_W-1:0]  pf_evict_addr
);
    localparam int NFR = 1 << FRAME_W;

    logic       occ_q  [NFR];
    logic       dead_q [NFR];
    logic [1:0] trn_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NFR; i++) begin
                occ_q[i]  <= 1'b0;
                dead_q[i] <= 1'b0;
            end
            trn_seen <= 2'd0;
        end else begin
            for (int i = 0; i < NFR; i++) begin
                if (acc_valid && !acc_hit && acc_frame == FRAME_W'(i)) begin
                    occ_q[i]  <= 1'b1;
                    dead_q[i] <= 1'b0;
                end else if (pf_valid && pf_frame == FRAME_W'(i)) begin
                    dead_q[i] <= 1'b1;
                end
            end
            if (trn_valid && trn_seen != 2'd2) trn_seen <= trn_seen + 2'd1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !pf_valid);

    // R6
    pf_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> ($past(acc_valid) && pf_frame == $past(acc_frame)
                      && pf_evict_addr == $past(acc_addr)));

    // R7
    one_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !dead_q[pf_frame]);

    // R8
    filled_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> occ_q[pf_frame]);

    // R5
    trained_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (trn_seen == 2'd2));

endmodule

bind dbp_predictor dbp_predictor_chk #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .acc_addr(acc_addr), .acc_hit(acc_hit), .trn_valid(trn_valid),
    .pf_valid(pf_valid), .pf_frame(pf_frame), .pf_evict_addr(pf_evict_addr)
);

// File: tb/dbp_predictor_test.sv
`timescale 1ns/1ps
module dbp_predictor_test;
    localparam int FW = 4, AW = 16, PW = 16, SW = 12, IW = 6;
    localparam int NF = 1 << FW, TD = 1 << IW, SMOD = 1 << SW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 0, acc_hit = 0, trn_valid = 0;
    logic [FW-1:0] acc_frame = 0, trn_frame = 0;
    logic [AW-1:0] acc_addr = 0, trn_addr = 0;
    logic [PW-1:0] acc_pc = 0;
    logic pf_valid;
    logic [FW-1:0] pf_frame;
    logic [AW-1:0] pf_evict_addr, pf_fetch_addr;

    always #2 clk = ~clk;

    dbp_predictor uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
        .acc_addr(acc_addr), .acc_pc(acc_pc), .acc_hit(acc_hit),
        .trn_valid(trn_valid), .trn_frame(trn_frame), .trn_addr(trn_addr),
        .pf_valid(pf_valid), .pf_frame(pf_frame),
        .pf_evict_addr(pf_evict_addr), .pf_fetch_addr(pf_fetch_addr)
    );

    int n_cmp = 0, n_bad = 0, n_pred = 0;
    bit done = 0;

    // behavioural reference: frame state 0 empty, 1 live, 2 dead
    int m_st [NF], m_sig [NF];
    int t_v [TD], t_sig [TD], t_nxt [TD], t_cnt [TD];
    int e_v = 0, e_f = 0, e_ev = 0, e_fe = 0;

    task automatic model_step();
        int ns, i, s, f;
        bit up, fire;
        fire = 0; up = 0; ns = 0;
        f = int'(acc_frame);
        if (acc_valid) begin
            up = !acc_hit || m_st[f] != 0;
            ns = acc_hit ? (m_sig[f] + int'(acc_pc)) % SMOD
                         : (int'(acc_addr) + int'(acc_pc)) % SMOD;
            i = ns % TD;
            fire = up && (!acc_hit || m_st[f] == 1)
                   && t_v[i] != 0 && t_sig[i] == ns && t_cnt[i] >= 2;
            e_ev = int'(acc_addr); e_f = f;
            if (fire) e_fe = t_nxt[i];
        end
        e_v = fire;
        if (fire) n_pred++;
        if (trn_valid && m_st[int'(trn_frame)] != 0) begin
            s = m_sig[int'(trn_frame)];
            i = s % TD;
            if (t_v[i] != 0 && t_sig[i] == s) begin
                if (t_nxt[i] == int'(trn_addr)) begin
                    if (t_cnt[i] < 3) t_cnt[i]++;
                end else if (t_cnt[i] > 0) t_cnt[i]--;
                else begin t_nxt[i] = int'(trn_addr); t_cnt[i] = 1; end
            end else begin
                t_v[i] = 1; t_sig[i] = s; t_nxt[i] = int'(trn_addr); t_cnt[i] = 1;
            end
        end
        if (up) begin
            m_sig[f] = ns;
            if (!acc_hit) m_st[f] = 1;
            if (fire) m_st[f] = 2;
        end
    endtask

    task automatic compare(input string tag);
        n_cmp++;
        if (pf_valid !== (e_v != 0) ||
            (e_v != 0 && (pf_frame !== e_f[FW-1:0] || pf_evict_addr !== e_ev[AW-1:0]
                          || pf_fetch_addr !== e_fe[AW-1:0]))) begin
            n_bad++;
            $display("FAIL %s: got v=%0b f=%0d ev=%h fe=%h, exp v=%0d f=%0d ev=%h fe=%h",
                     tag, pf_valid, pf_frame, pf_evict_addr, pf_fetch_addr,
                     e_v, e_f, e_ev[AW-1:0], e_fe[AW-1:0]);
        end
    endtask

    task automatic cyc(input string tag, input bit av, input int af, input int aa,
                       input int ap, input bit ah, input bit tv, input int tf, input int ta);
        acc_valid = av; acc_frame = af[FW-1:0]; acc_addr = aa[AW-1:0];
        acc_pc = ap[PW-1:0]; acc_hit = ah;
        trn_valid = tv; trn_frame = tf[FW-1:0]; trn_addr = ta[AW-1:0];
        @(posedge clk);
        #0.5;
        if (rst_n) model_step();
        else e_v = 0;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic acc(input string tag, input int f, input int a, input int pc, input bit h);
        cyc(tag, 1, f, a, pc, h, 0, 0, 0);
    endtask

    task automatic trn(input string tag, input int f, input int a);
        cyc(tag, 0, 0, 0, 0, 0, 1, f, a);
    endtask

    task automatic life_a(input string tag);
        acc(tag, 3, 'h0120, 'h0400, 0);
        acc(tag, 3, 'h0120, 'h0410, 1);
        acc(tag, 3, 'h0120, 'h0420, 1);
    endtask

    task automatic check(input string tag, input bit ok, input int got, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int p0;
        for (int i = 0; i < NF; i++) begin m_st[i] = 0; m_sig[i] = 0; end
        for (int i = 0; i < TD; i++) begin t_v[i] = 0; t_sig[i] = 0; t_nxt[i] = 0; t_cnt[i] = 0; end
        @(negedge clk);
        // R1: quiet during and just after reset
        for (int k = 0; k < 3; k++) cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1;
        cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0);

        // R3 allocation, R5 no prediction at count 1, R6 prediction at count 2
        for (int k = 0; k < 3; k++) begin
            p0 = n_pred;
            life_a(k < 2 ? "R5" : "R6");
            if (k < 2) check("R5", n_pred == p0, n_pred - p0, 0);
            else       check("R6", n_pred == p0 + 1, n_pred - p0, 1);
            if (k == 2) acc("R7", 3, 'h0120, 'h0420, 1);
            trn("R3", 3, 'h0340);
            acc("R2", 3, 'h0340, 'h0500, 0);
            trn("R3", 3, 'h0120);
        end
        // R7: miss restarts the trace; prediction possible again
        p0 = n_pred;
        life_a("R7");
        check("R7", n_pred == p0 + 1, n_pred - p0, 1);
        // R4: mismatching trainings weaken then replace the next address
        trn("R4", 3, 'h0777);
        trn("R4", 3, 'h0777);
        trn("R4", 3, 'h0777);
        trn("R4", 3, 'h0777);
        trn("R4", 3, 'h0777);
        acc("R4", 3, 'h0777, 'h0600, 0);
        trn("R4", 3, 'h0120);
        life_a("R4");
        // R8: hit to never-filled frame 9 is ignored
        acc("R8", 9, 'h0000, 'h0001, 1);
        acc("R8", 9, 'h0000, 'h0000, 1);
        // R9: training on empty frame 9 (signature would be 0) leaves table alone
        trn("R9", 9, 'h0aaa);
        trn("R9", 9, 'h0aaa);
        trn("R9", 9, 'h0aaa);
        p0 = n_pred;
        acc("R9", 5, 'h0000, 'h0000, 0);
        check("R9", n_pred == p0, n_pred - p0, 0);
        // R10: access and training to the same frame in one cycle
        life_a("R10");
        cyc("R10", 1, 3, 'h0340, 'h0500, 0, 1, 3, 'h0340);
        cyc("R10", 1, 3, 'h0340, 'h0510, 1, 1, 3, 'h0120);
        acc("R10", 3, 'h0120, 'h0400, 0);

        // R2: repetitive pseudo-random traffic with signature wraparound
        p0 = n_pred;
        for (int l = 0; l < 500; l++) begin
            int f, a, na;
            f = $urandom_range(0, 7);
            a = 'h0f00 + 'h100 * $urandom_range(0, 7);
            acc("R2", f, a, 'hff0 + a, 0);
            for (int h = 0; h < 1 + (a >> 8) % 3; h++)
                acc("R2", f, a, 'h0ff0 + 16 * h + (a >> 8), 1);
            if ($urandom_range(0, 7) == 0) acc("R8", 8 + $urandom_range(0, 7), a, 'h30, 1);
            na = ($urandom_range(0, 7) == 0) ? 'h0f00 + 'h100 * $urandom_range(0, 7)
                                              : 'h0f00 + ((a - 'h0f00 + 'h100) % 'h800);
            trn("R4", f, na);
            acc("R2", f, na, 'hff0 + na, 0);
        end
        check("R2", n_pred > p0, n_pred - p0, 1);
        finish_run();
    end
endmodule